// File: doc/BRIEF.md
# Dual-Edge Capture Timer

This block is a free-running up-counter with two capture registers. The count advances on one of four sources: the synchronized external capture pin, or one of three prescaler tick strobes from outside the block. A single mode register starts and stops the counter and chooses the count source. It can also make the counter return to zero when it reaches the compare value. It chooses which signal edges copy the running count into the capture registers. A bus write can also take an immediate snapshot of the count.

Hardware capture can watch the external pin or an internal timer output. Rising edges load capture register 0 and falling edges load capture register 1. Mode 01 uses only the pin's rising edge. A one-cycle interrupt pulse is raised on each rising edge of the pin while hardware capture is enabled. Both edge sources pass through a synchronizer before their edges are detected. A plain register bus gives access to the mode, the compare value, both capture registers and the live count. Writes are registered and reads are combinational.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset the mode register reads 0x0020, and the counter, both capture registers and `irq` are 0.
- R2: Mode bits [1:0] select the count source: 00 counts synchronized rising edges of `cap_pin`, 01 counts `tick_t1`, 10 counts `tick_t4`, and 11 counts `tick_t16`. Strobes from unselected sources have no effect.
- R3: Mode bit 6 set to 1 lets the counter step by one on each selected event. Set to 0, it holds the count.
- R4: With mode bit 2 set, an event taken while the count equals the compare register loads 0, so the counter cycles through compare+1 values. With bit 2 clear, the counter counts past the compare value and wraps from all-ones to 0.
- R5: Capture mode (mode bits [4:3]) 00 loads neither capture register from hardware edges.
- R6: Capture mode 01 loads capture register 0 with the count on each synchronized rising edge of `cap_pin`. Falling edges are ignored.
- R7: Capture mode 10 loads capture register 0 on rising edges of `cap_pin` and capture register 1 on its falling edges.
- R8: Capture mode 11 loads capture register 0 on rising edges of `tmr_out_in` and capture register 1 on its falling edges. `cap_pin` edges load neither register.
- R9: A mode write with bit 5 equal to 0 copies the current count into capture register 0 at that write. The same write with bit 5 equal to 1 copies nothing. Bit 5 always reads back as 1.
- R10: In capture modes 01, 10 and 11, `irq` pulses high for exactly one cycle per synchronized rising edge of `cap_pin`. It stays low for falling edges of `cap_pin`, for `tmr_out_in` edges, and in capture mode 00.
- R11: The bus addresses are 0 mode, 1 compare, 2 capture 0, 3 capture 1 and 4 live count. Mode bit 7 and bits above 7 read 0.
- R12: `cap_pin` and `tmr_out_in` pass through a two-flop synchronizer. An edge takes effect at the third rising clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| tick_t1 | input | 1 | Prescaler tick, finest rate |
| tick_t4 | input | 1 | Prescaler tick, middle rate |
| tick_t16 | input | 1 | Prescaler tick, coarsest rate |
| cap_pin | input | 1 | External capture/count pin (asynchronous) |
| tmr_out_in | input | 1 | Internal timer output used as a capture source |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench sweeps compare values against event counts. A counter that clears one event early or late shows the wrong residue, and one that ignores the clear enable stops short of the expected count. It drives 65537 events to catch a counter that saturates at all-ones instead of wrapping to 0. With the count frozen, it walks through all four capture modes and checks both capture registers after each edge of each source. A swapped edge polarity or source would load the wrong register or leave it stale. It also counts `irq` cycles for every edge, and a level-style or wrongly gated interrupt would give the wrong count. It checks that the software-capture bit acts only when written as 0, and that strobes from unselected tick sources are ignored.

// File: rtl/ect_pkg.sv
package ect_pkg;
   typedef enum logic [1:0] {
      SRC_PIN = 2'b00,
      SRC_T1  = 2'b01,
      SRC_T4  = 2'b10,
      SRC_T16 = 2'b11
   } src_sel_e;

   typedef enum logic [1:0] {
      CAPM_OFF      = 2'b00,
      CAPM_PIN_RISE = 2'b01,
      CAPM_PIN_BOTH = 2'b10,
      CAPM_TMR_BOTH = 2'b11
   } cap_mode_e;

   localparam logic [2:0] ADR_MODE  = 3'd0;
   localparam logic [2:0] ADR_CMP   = 3'd1;
   localparam logic [2:0] ADR_CAP0  = 3'd2;
   localparam logic [2:0] ADR_CAP1  = 3'd3;
   localparam logic [2:0] ADR_COUNT = 3'd4;

   localparam int MB_CLR   = 2;
   localparam int MB_SWCAP = 5;
   localparam int MB_RUN   = 6;
   localparam int MODE_W   = 8;
endpackage

// File: rtl/ect_sync_edge.sv
module ect_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_chk
      $error("ect_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage;
   logic              last;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[i] <= 1'b0;
            else        stage[i] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[i] <= 1'b0;
            else        stage[i] <= stage[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= 1'b0;
      else        last <= stage[STAGES-1];
   end

   assign rise = stage[STAGES-1] & ~last;
   assign fall = ~stage[STAGES-1] & last;
endmodule

// File: rtl/ect_counter.sv
module ect_counter
   import ect_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr_en,
   input  src_sel_e         src_sel,
   input  logic             tick_t1,
   input  logic             tick_t4,
   input  logic             tick_t16,
   input  logic             pin_rise,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] count
);
   logic step;

   always_comb begin
      unique case (src_sel)
         SRC_PIN: step = pin_rise;
         SRC_T1:  step = tick_t1;
         SRC_T4:  step = tick_t4;
         SRC_T16: step = tick_t16;
         default: step = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (run && step) begin
         if (clr_en && (count == cmp)) count <= '0;
         else                          count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/ect_capture.sv
module ect_capture
   import ect_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cap_mode_e        mode,
   input  logic             sw_cap,
   input  logic             pin_rise,
   input  logic             pin_fall,
   input  logic             tmr_rise,
   input  logic             tmr_fall,
   input  logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] cap0,
   output logic [CNT_W-1:0] cap1,
   output logic             irq
);
   logic load0, load1;

   always_comb begin
      load0 = 1'b0;
      load1 = 1'b0;
      unique case (mode)
         CAPM_OFF: ;
         CAPM_PIN_RISE: load0 = pin_rise;
         CAPM_PIN_BOTH: begin
            load0 = pin_rise;
            load1 = pin_fall;
         end
         CAPM_TMR_BOTH: begin
            load0 = tmr_rise;
            load1 = tmr_fall;
         end
         default: ;
      endcase
   end

   // software snapshot has priority over a hardware edge in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap0 <= '0;
         cap1 <= '0;
         irq  <= 1'b0;
      end else begin
         if (sw_cap)     cap0 <= count;
         else if (load0) cap0 <= count;
         if (load1)      cap1 <= count;
         irq <= pin_rise && (mode != CAPM_OFF);
      end
   end
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
   import ect_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic [2:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic             tick_t1,
   input  logic             tick_t4,
   input  logic             tick_t16,
   input  logic             cap_pin,
   input  logic             tmr_out_in,
   output logic             irq
);
   if (CNT_W < MODE_W) begin : g_chk
      $error("edge_capture_timer: CNT_W must hold the mode register");
   end

   src_sel_e         src_sel_q;
   cap_mode_e        cap_mode_q;
   logic             clr_en_q;
   logic             run_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] cap0, cap1;
   logic             pin_rise, pin_fall, tmr_rise, tmr_fall;
   logic             mode_wr, sw_cap;
   logic [MODE_W-1:0] mode_rd;

   assign mode_wr = bus_we && (bus_addr == ADR_MODE);
   assign sw_cap  = mode_wr && !bus_wdata[MB_SWCAP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_sel_q  <= SRC_PIN;
         cap_mode_q <= CAPM_OFF;
         clr_en_q   <= 1'b0;
         run_q      <= 1'b0;
         cmp_q      <= '0;
      end else begin
         if (mode_wr) begin
            src_sel_q  <= src_sel_e'(bus_wdata[1:0]);
            clr_en_q   <= bus_wdata[MB_CLR];
            cap_mode_q <= cap_mode_e'(bus_wdata[4:3]);
            run_q      <= bus_wdata[MB_RUN];
         end
         if (bus_we && (bus_addr == ADR_CMP)) cmp_q <= bus_wdata;
      end
   end

   ect_sync_edge #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .async_in(cap_pin),
      .rise(pin_rise), .fall(pin_fall)
   );

   ect_sync_edge #(.STAGES(SYNC_STAGES)) u_tmr_sync (
      .clk(clk), .rst_n(rst_n), .async_in(tmr_out_in),
      .rise(tmr_rise), .fall(tmr_fall)
   );

   ect_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .run(run_q), .clr_en(clr_en_q),
      .src_sel(src_sel_q), .tick_t1(tick_t1), .tick_t4(tick_t4),
      .tick_t16(tick_t16), .pin_rise(pin_rise), .cmp(cmp_q), .count(count)
   );

   ect_capture #(.CNT_W(CNT_W)) u_capture (
      .clk(clk), .rst_n(rst_n), .mode(cap_mode_q), .sw_cap(sw_cap),
      .pin_rise(pin_rise), .pin_fall(pin_fall),
      .tmr_rise(tmr_rise), .tmr_fall(tmr_fall),
      .count(count), .cap0(cap0), .cap1(cap1), .irq(irq)
   );

   assign mode_rd = {1'b0, run_q, 1'b1, cap_mode_q, clr_en_q, src_sel_q};

   always_comb begin
      unique case (bus_addr)
         ADR_MODE:  bus_rdata = {{(CNT_W-MODE_W){1'b0}}, mode_rd};
         ADR_CMP:   bus_rdata = cmp_q;
         ADR_CAP0:  bus_rdata = cap0;
         ADR_CAP1:  bus_rdata = cap1;
         ADR_COUNT: bus_rdata = count;
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       bus_addr,
   input logic [CNT_W-1:0] bus_rdata,
   input logic             irq,
   input logic             run_q,
   input logic             clr_en_q,
   input logic [1:0]       cap_mode_q,
   input logic [CNT_W-1:0] cmp_q,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] cap1
);
   // R10: interrupt is a single-cycle pulse
   p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R10: no interrupt while capture is disabled
   p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(cap_mode_q) != 2'b00));

   // R5/R6: capture register 1 untouched in modes 00 and 01
   p_cap1_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_mode_q == 2'b00 || cap_mode_q == 2'b01) |=> $stable(cap1));

   // R3: stopped counter holds its value
   p_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> $stable(count));

   // R4: clear on compare match
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && clr_en_q && count == cmp_q) |=> (count == '0 || count == $past(count)));

   // R4: wrap from all-ones to zero without clear
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !clr_en_q && count == {CNT_W{1'b1}}) |=> (count == '0 || count == {CNT_W{1'b1}}));

   // R11/R9: mode read shows bit 7 low and bit 5 high
   p_mode_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 3'd0) |-> (bus_rdata[7] == 1'b0 && bus_rdata[5] == 1'b1));
endmodule

bind edge_capture_timer ect_checker #(.CNT_W(CNT_W)) u_ect_checker (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
   .irq(irq), .run_q(run_q), .clr_en_q(clr_en_q), .cap_mode_q(cap_mode_q),
   .cmp_q(cmp_q), .count(count), .cap1(cap1)
);

// File: tb/edge_capture_timer_tb.sv
`timescale 1ns/1ps
module edge_capture_timer_tb;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_we = 1'b0;
   logic [2:0]   bus_addr = 3'd0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic         tick_t1 = 1'b0, tick_t4 = 1'b0, tick_t16 = 1'b0;
   logic         cap_pin = 1'b0, tmr_out_in = 1'b0;
   logic         irq;

   int total = 0;
   int bad = 0;
   int irq_seen;
   logic [W-1:0] rv;

   always #2.5 clk = ~clk;

   edge_capture_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_t1(tick_t1),
      .tick_t4(tick_t4), .tick_t16(tick_t16), .cap_pin(cap_pin),
      .tmr_out_in(tmr_out_in), .irq(irq)
   );

   // mode word: [6] run, [5] no-snapshot, [4:3] capture mode, [2] clear, [1:0] source
   function automatic logic [W-1:0] mw(input logic [1:0] src, input logic run,
                                       input logic clr, input logic [1:0] cm,
                                       input logic nosw);
      return W'({1'b0, run, nosw, cm, clr, src});
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cap_pin = 1'b0;
      tmr_out_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // which: 1 = t1, 4 = t4, 16 = t16
   task automatic pulse(input int which, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_t1 = (which == 1); tick_t4 = (which == 4); tick_t16 = (which == 16);
         @(negedge clk);
         tick_t1 = 1'b0; tick_t4 = 1'b0; tick_t16 = 1'b0;
      end
   endtask

   task automatic set_pin(input logic v);
      @(negedge clk);
      cap_pin = v;
      irq_seen = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (irq) irq_seen++;
      end
   endtask

   task automatic set_tmr(input logic v);
      @(negedge clk);
      tmr_out_in = v;
      irq_seen = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (irq) irq_seen++;
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      do_reset();
      // R1 reset state
      rd(3'd0, rv); check("R1 mode", rv, 16'h0020);
      rd(3'd4, rv); check("R1 count", rv, 16'h0);
      rd(3'd2, rv); check("R1 cap0", rv, 16'h0);
      rd(3'd3, rv); check("R1 cap1", rv, 16'h0);
      check("R1 irq", W'(irq), 16'h0);

      // R11 reserved bit 7 reads 0, bit 5 reads 1
      wr(3'd0, 16'h00A0 | mw(2'b01, 1'b0, 1'b1, 2'b00, 1'b1));
      rd(3'd0, rv); check("R11 mode readback", rv, 16'h0025);
      wr(3'd1, 16'hBEEF);
      rd(3'd1, rv); check("R11 compare readback", rv, 16'hBEEF);

      // R3 stopped counter
      do_reset();
      wr(3'd0, mw(2'b01, 1'b0, 1'b0, 2'b00, 1'b1));
      pulse(1, 5);
      rd(3'd4, rv); check("R3 stopped", rv, 16'd0);
      wr(3'd0, mw(2'b01, 1'b1, 1'b0, 2'b00, 1'b1));
      pulse(1, 6);
      rd(3'd4, rv); check("R3 running", rv, 16'd6);

      // R2 source selection
      do_reset();
      wr(3'd0, mw(2'b10, 1'b1, 1'b0, 2'b00, 1'b1));
      pulse(1, 3); pulse(16, 2); pulse(4, 4);
      rd(3'd4, rv); check("R2 t4 select", rv, 16'd4);
      do_reset();
      wr(3'd0, mw(2'b11, 1'b1, 1'b0, 2'b00, 1'b1));
      pulse(4, 3); pulse(16, 2); pulse(1, 2);
      rd(3'd4, rv); check("R2 t16 select", rv, 16'd2);
      do_reset();
      wr(3'd0, mw(2'b00, 1'b1, 1'b0, 2'b00, 1'b1));
      for (int i = 0; i < 7; i++) begin
         set_pin(1'b1); set_pin(1'b0);
      end
      pulse(1, 3);
      rd(3'd4, rv); check("R2 R12 pin source", rv, 16'd7);

      // R4 clear-on-match sweep
      for (int c = 1; c <= 4; c++) begin
         for (int n = 0; n < 10; n++) begin
            do_reset();
            wr(3'd1, W'(c));
            wr(3'd0, mw(2'b01, 1'b1, 1'b1, 2'b00, 1'b1));
            pulse(1, n);
            rd(3'd4, rv); check("R4 clear on match", rv, W'(n % (c + 1)));
         end
      end
      do_reset();
      wr(3'd1, 16'd3);
      wr(3'd0, mw(2'b01, 1'b1, 1'b0, 2'b00, 1'b1));
      pulse(1, 9);
      rd(3'd4, rv); check("R4 no clear", rv, 16'd9);

      // R4 wrap
      do_reset();
      wr(3'd0, mw(2'b01, 1'b1, 1'b0, 2'b00, 1'b1));
      @(negedge clk); tick_t1 = 1'b1;
      repeat (65537) @(negedge clk);
      tick_t1 = 1'b0;
      rd(3'd4, rv); check("R4 wrap", rv, 16'd1);

      // capture modes with frozen count
      do_reset();
      wr(3'd0, mw(2'b01, 1'b1, 1'b0, 2'b00, 1'b1));
      pulse(1, 5);
      wr(3'd0, mw(2'b01, 1'b0, 1'b0, 2'b01, 1'b1));
      set_pin(1'b1);
      check("R10 irq mode01 rise", W'(irq_seen), 16'd1);
      rd(3'd2, rv); check("R6 cap0 rise", rv, 16'd5);
      rd(3'd3, rv); check("R6 cap1 untouched", rv, 16'd0);
      wr(3'd0, mw(2'b01, 1'b1, 1'b0, 2'b01, 1'b1));
      pulse(1, 2);
      wr(3'd0, mw(2'b01, 1'b0, 1'b0, 2'b01, 1'b1));
      set_pin(1'b0);
      check("R10 irq on fall", W'(irq_seen), 16'd0);
      rd(3'd2, rv); check("R6 fall ignored cap0", rv, 16'd5);
      rd(3'd3, rv); check("R6 fall ignored cap1", rv, 16'd0);

      // mode 10: count now 7
      wr(3'd0, mw(2'b01, 1'b1, 1'b0, 2'b10, 1'b1));
      pulse(1, 1);
      wr(3'd0, mw(2'b01, 1'b0, 1'b0, 2'b10, 1'b1));
      set_pin(1'b1);
      check("R10 irq mode10", W'(irq_seen), 16'd1);
      rd(3'd2, rv); check("R7 cap0 rise", rv, 16'd8);
      wr(3'd0, mw(2'b01, 1'b1, 1'b0, 2'b10, 1'b1));
      pulse(1, 2);
      wr(3'd0, mw(2'b01, 1'b0, 1'b0, 2'b10, 1'b1));
      set_pin(1'b0);
      rd(3'd3, rv); check("R7 cap1 fall", rv, 16'd10);
      rd(3'd2, rv); check("R7 cap0 kept", rv, 16'd8);

      // mode 11: count 10 -> 14
      wr(3'd0, mw(2'b01, 1'b1, 1'b0, 2'b11, 1'b1));
      pulse(1, 4);
      wr(3'd0, mw(2'b01, 1'b0, 1'b0, 2'b11, 1'b1));
      set_tmr(1'b1);
      check("R10 no irq on timer edge", W'(irq_seen), 16'd0);
      rd(3'd2, rv); check("R8 cap0 timer rise", rv, 16'd14);
      wr(3'd0, mw(2'b01, 1'b1, 1'b0, 2'b11, 1'b1));
      pulse(1, 1);
      wr(3'd0, mw(2'b01, 1'b0, 1'b0, 2'b11, 1'b1));
      set_pin(1'b1);
      check("R10 irq mode11 pin rise", W'(irq_seen), 16'd1);
      rd(3'd2, rv); check("R8 pin rise ignored", rv, 16'd14);
      set_pin(1'b0);
      rd(3'd3, rv); check("R8 pin fall ignored", rv, 16'd10);
      set_tmr(1'b0);
      rd(3'd3, rv); check("R8 cap1 timer fall", rv, 16'd15);

      // mode 00: count 15 -> 16
      wr(3'd0, mw(2'b01, 1'b1, 1'b0, 2'b00, 1'b1));
      pulse(1, 1);
      wr(3'd0, mw(2'b01, 1'b0, 1'b0, 2'b00, 1'b1));
      set_pin(1'b1);
      check("R10 no irq mode00", W'(irq_seen), 16'd0);
      set_pin(1'b0);
      set_tmr(1'b1); set_tmr(1'b0);
      rd(3'd2, rv); check("R5 cap0 held", rv, 16'd14);
      rd(3'd3, rv); check("R5 cap1 held", rv, 16'd15);

      // R9 software snapshot
      wr(3'd0, mw(2'b01, 1'b0, 1'b0, 2'b00, 1'b0));
      rd(3'd2, rv); check("R9 snapshot", rv, 16'd16);
      rd(3'd0, rv); check("R9 bit5 reads 1", rv, 16'h0021);
      wr(3'd0, mw(2'b01, 1'b1, 1'b0, 2'b00, 1'b1));
      pulse(1, 1);
      wr(3'd0, mw(2'b01, 1'b0, 1'b0, 2'b00, 1'b1));
      rd(3'd2, rv); check("R9 write 1 no snapshot", rv, 16'd16);
      rd(3'd4, rv); check("R9 count", rv, 16'd17);

      finish_run();
   end
endmodule